// File: doc/BRIEF.md
# Security Domain Switch Controller

This per-hart unit moves a hart from one hardware-visible security domain to the next. Software running in the current domain prepares the incoming domain's identifier and capability mask in a writable "next" register. It then issues a switch request. The current domain's identifier and capabilities are visible in a read-only "current" register. Each capability bit stands for one scarce optional resource, such as a shared multiply/divide unit.

A switch runs in a fixed order. First, every resource holding persistent state of the outgoing domain receives a flush request, and the unit waits until each one reports that it is empty. Next, the outgoing domain's allocations are released with a single pulse. Then every allocator is asked to lock resources for the incoming domain. Each allocator answers with a grant strobe and a mask of capabilities it could not lock. The unit ORs these answers into one result. A zero result commits the next register into the current register. A nonzero result leaves the current domain in place, and the flushed state is not restored.

The pipeline stays stalled from the request until the one-cycle done strobe. A build parameter selects the single-hart variant, in which release and allocation are skipped and the switch commits as soon as all flushes have completed. A wait bound turns a stuck flush or a missing grant into a failed switch with a distinct flag.

Top module: `dsw_switch_ctrl`

## Requirements
- R1: The CSR port has two registers of ID_W+CAP_W bits, each with the domain identifier in bits [ID_W-1:0] and the capability mask in the bits above. Address 0 is the current register and is read-only: writes to it are ignored. Address 1 is the next register and is writable. Both reset to zero. A read returns the addressed register combinationally.
- R2: `sw_stall` is high in the cycle `sw_req` is sampled and in every cycle up to and including the cycle in which `sw_done` is high. `sw_done` is high for exactly one cycle per switch. In reset and when idle, `sw_stall`, `sw_done` and `sw_result` are all 0.
- R3: A write to the next register is ignored in any cycle where `sw_stall` is high.
- R4: Every bit of `flush_req` pulses for one cycle, in the cycle after the request. `rel_req` pulses one cycle after the cycle in which the last outstanding `flush_done` bit is seen, and it carries the current identifier. `alloc_req` rises only in the cycle after `rel_req`. It stays high until every `alloc_gnt` bit has been seen, and it carries the next identifier and capability mask.
- R5: On success, `sw_done` is high in the cycle after the last grant, with `sw_result` equal to 0. From the following cycle, the current register equals the next register.
- R6: `sw_result` is the OR of each granting allocator's deny mask (allocator i in `alloc_deny` bits [i*CAP_W +: CAP_W]), restricted to the capability bits requested in the next register. Bit i set means capability i could not be locked. Any nonzero value is a failure.
- R7: After a failed switch, the current register and the next register both keep their values.
- R8: With SINGLE_HART=1, `rel_req` and `alloc_req` never rise. `sw_done` with result 0 appears one cycle after the last flush acknowledgement.
- R9: If a flush wait or an allocation wait lasts TMO_CYC cycles without completing, the switch ends with `sw_done`, `sw_timeout` high and an all-ones `sw_result`. The current register is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| csr_we | input | 1 | CSR write strobe |
| csr_addr | input | 1 | CSR select: 0 current, 1 next |
| csr_wdata | input | ID_W+CAP_W | CSR write data {capabilities, identifier} |
| csr_rdata | output | ID_W+CAP_W | CSR read data of the selected register |
| sw_req | input | 1 | Switch request strobe from the pipeline |
| sw_stall | output | 1 | Pipeline hold while a switch runs |
| sw_done | output | 1 | One-cycle switch completion strobe |
| sw_result | output | CAP_W | 0 on success, failure code otherwise |
| sw_timeout | output | 1 | Set with sw_done when a wait bound expired |
| flush_req | output | N_FLUSH | One-cycle flush pulse to each resource |
| flush_id | output | ID_W | Outgoing domain identifier for flushing |
| flush_done | input | N_FLUSH | Per-resource flush-complete strobes |
| rel_req | output | 1 | One-cycle release pulse to allocators |
| rel_id | output | ID_W | Domain whose resources are released |
| alloc_req | output | 1 | Allocation request, held until all grants seen |
| alloc_id | output | ID_W | Incoming domain identifier |
| alloc_cap | output | CAP_W | Incoming domain capability mask |
| alloc_gnt | input | N_ALLOC | Per-allocator answer strobes |
| alloc_deny | input | N_ALLOC*CAP_W | Per-allocator mask of capabilities not locked |

## Verification
The bench builds two instances side by side on shared stimulus. The first has three flush targets, two allocators and a 40-cycle wait bound, which lets a hung flush reach a timeout quickly. The second is the single-hart variant with the same bound. Because both share the same CSR writes and flush acknowledgements, a switch denied by an allocator commits in one instance and fails in the other, and a comparison of both register sets on every clock exposes any error in the commit or hold paths. Staggered acknowledgement and grant delays, zero-delay grants, denied capabilities that were not requested, and a CSR write issued in the middle of a flush cover the ordering and locking rules.

// File: rtl/dsw_pkg.sv
package dsw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FLUSH,
        ST_WAIT_FLUSH,
        ST_RELEASE,
        ST_ALLOCATE,
        ST_COMMIT,
        ST_FAIL
    } dsw_state_e;

    // CSR select values
    localparam logic CSR_SEL_CUR = 1'b0;
    localparam logic CSR_SEL_NXT = 1'b1;

endpackage

// File: rtl/dsw_csr_file.sv
module dsw_csr_file
    import dsw_pkg::*;
#(
    parameter int ID_W  = 8,
    parameter int CAP_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic                    wr_addr,
    input  logic [ID_W+CAP_W-1:0]   wr_data,
    input  logic                    rd_addr,
    input  logic                    lock,
    input  logic                    commit,
    output logic [ID_W+CAP_W-1:0]   rd_data,
    output logic [ID_W-1:0]         cur_id,
    output logic [ID_W-1:0]         nxt_id,
    output logic [CAP_W-1:0]        nxt_cap
);

    localparam int CSR_W = ID_W + CAP_W;

    typedef struct packed {
        logic [CSR_W-1:0] cur;
        logic [CSR_W-1:0] nxt;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (commit) begin
            regs_d.cur = regs_q.nxt;
        end
        if (wr_en && !lock && (wr_addr == CSR_SEL_NXT)) begin
            regs_d.nxt = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rd_data = (rd_addr == CSR_SEL_NXT) ? regs_q.nxt : regs_q.cur;
    assign cur_id  = regs_q.cur[ID_W-1:0];
    assign nxt_id  = regs_q.nxt[ID_W-1:0];
    assign nxt_cap = regs_q.nxt[CSR_W-1:ID_W];

    // current register only moves on a commit
    assert_cur_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(regs_q.cur));

    assert_commit_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (regs_q.cur == $past(regs_q.nxt)));

    assert_next_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> $stable(regs_q.nxt));

endmodule

// File: rtl/dsw_ack_collect.sv
module dsw_ack_collect #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic [N-1:0] ack,
    output logic         all_seen
);

    logic [N-1:0] seen_d, seen_q;

    always_comb begin
        if (clear) begin
            seen_d = '0;
        end else begin
            seen_d = seen_q | ack;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= '0;
        end else begin
            seen_q <= seen_d;
        end
    end

    assign all_seen = ((seen_q | ack) == {N{1'b1}});

    // collected acknowledgements never drop except on clear
    assert_seen_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> ((seen_q & $past(seen_q)) == $past(seen_q)));

endmodule

// File: rtl/dsw_wait_timer.sv
module dsw_wait_timer #(
    parameter int TMO_CYC = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expired
);

    localparam int CNT_W = $clog2(TMO_CYC + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TMO_CYC - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (run && (cnt_q != LIMIT)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == LIMIT);

    assert_timer_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIMIT);

endmodule

// File: rtl/dsw_switch_ctrl.sv
module dsw_switch_ctrl
    import dsw_pkg::*;
#(
    parameter int ID_W        = 8,
    parameter int CAP_W       = 4,
    parameter int N_FLUSH     = 3,
    parameter int N_ALLOC     = 2,
    parameter int TMO_CYC     = 1024,
    parameter bit SINGLE_HART = 1'b0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      csr_we,
    input  logic                      csr_addr,
    input  logic [ID_W+CAP_W-1:0]     csr_wdata,
    output logic [ID_W+CAP_W-1:0]     csr_rdata,
    input  logic                      sw_req,
    output logic                      sw_stall,
    output logic                      sw_done,
    output logic [CAP_W-1:0]          sw_result,
    output logic                      sw_timeout,
    output logic [N_FLUSH-1:0]        flush_req,
    output logic [ID_W-1:0]           flush_id,
    input  logic [N_FLUSH-1:0]        flush_done,
    output logic                      rel_req,
    output logic [ID_W-1:0]           rel_id,
    output logic                      alloc_req,
    output logic [ID_W-1:0]           alloc_id,
    output logic [CAP_W-1:0]          alloc_cap,
    input  logic [N_ALLOC-1:0]        alloc_gnt,
    input  logic [N_ALLOC*CAP_W-1:0]  alloc_deny
);

    typedef struct packed {
        dsw_state_e       st;
        logic [CAP_W-1:0] code;
        logic             tmo;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             busy;
    logic             flush_all;
    logic             alloc_all;
    logic             expired;
    logic [ID_W-1:0]  cur_id;
    logic [ID_W-1:0]  nxt_id;
    logic [CAP_W-1:0] nxt_cap;
    logic [CAP_W-1:0] deny_now;

    assign busy = sw_req || (ctl_q.st != ST_IDLE);

    dsw_csr_file #(
        .ID_W  (ID_W),
        .CAP_W (CAP_W)
    ) u_csr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (csr_we),
        .wr_addr (csr_addr),
        .wr_data (csr_wdata),
        .rd_addr (csr_addr),
        .lock    (busy),
        .commit  (ctl_q.st == ST_COMMIT),
        .rd_data (csr_rdata),
        .cur_id  (cur_id),
        .nxt_id  (nxt_id),
        .nxt_cap (nxt_cap)
    );

    dsw_ack_collect #(.N(N_FLUSH)) u_flush_acks (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (ctl_q.st == ST_FLUSH),
        .ack      (flush_done),
        .all_seen (flush_all)
    );

    dsw_ack_collect #(.N(N_ALLOC)) u_alloc_acks (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (ctl_q.st == ST_RELEASE),
        .ack      (alloc_gnt),
        .all_seen (alloc_all)
    );

    dsw_wait_timer #(.TMO_CYC(TMO_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   ((ctl_q.st == ST_FLUSH) || (ctl_q.st == ST_RELEASE)),
        .run     ((ctl_q.st == ST_WAIT_FLUSH) || (ctl_q.st == ST_ALLOCATE)),
        .expired (expired)
    );

    // OR of deny masks from allocators answering this cycle
    logic [CAP_W-1:0] deny_chain [N_ALLOC+1];
    assign deny_chain[0] = '0;
    for (genvar gi = 0; gi < N_ALLOC; gi++) begin : g_deny
        assign deny_chain[gi+1] = deny_chain[gi] |
            (alloc_gnt[gi] ? alloc_deny[gi*CAP_W +: CAP_W] : '0);
    end
    assign deny_now = deny_chain[N_ALLOC] & nxt_cap;

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.st)
            ST_IDLE: begin
                ctl_d.code = '0;
                ctl_d.tmo  = 1'b0;
                if (sw_req) begin
                    ctl_d.st = ST_FLUSH;
                end
            end
            ST_FLUSH: begin
                ctl_d.st = ST_WAIT_FLUSH;
            end
            ST_WAIT_FLUSH: begin
                if (flush_all) begin
                    ctl_d.st = SINGLE_HART ? ST_COMMIT : ST_RELEASE;
                end else if (expired) begin
                    ctl_d.st   = ST_FAIL;
                    ctl_d.code = '1;
                    ctl_d.tmo  = 1'b1;
                end
            end
            ST_RELEASE: begin
                ctl_d.st   = ST_ALLOCATE;
                ctl_d.code = '0;
            end
            ST_ALLOCATE: begin
                ctl_d.code = ctl_q.code | deny_now;
                if (alloc_all) begin
                    ctl_d.st = ((ctl_q.code | deny_now) != '0) ? ST_FAIL : ST_COMMIT;
                end else if (expired) begin
                    ctl_d.st   = ST_FAIL;
                    ctl_d.code = '1;
                    ctl_d.tmo  = 1'b1;
                end
            end
            ST_COMMIT: begin
                ctl_d.st = ST_IDLE;
            end
            ST_FAIL: begin
                ctl_d.st = ST_IDLE;
            end
            default: begin
                ctl_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, code: '0, tmo: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign sw_stall   = busy;
    assign sw_done    = (ctl_q.st == ST_COMMIT) || (ctl_q.st == ST_FAIL);
    assign sw_result  = (ctl_q.st == ST_FAIL) ? ctl_q.code : '0;
    assign sw_timeout = (ctl_q.st == ST_FAIL) && ctl_q.tmo;
    assign flush_req  = {N_FLUSH{ctl_q.st == ST_FLUSH}};
    assign flush_id   = cur_id;
    assign rel_req    = (ctl_q.st == ST_RELEASE);
    assign rel_id     = cur_id;
    assign alloc_req  = (ctl_q.st == ST_ALLOCATE);
    assign alloc_id   = nxt_id;
    assign alloc_cap  = nxt_cap;

    assert_stall_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_stall && !sw_done) |=> sw_stall);

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sw_done |=> !sw_done);

    assert_release_after_flush_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rel_req |-> $past(flush_all));

    assert_alloc_after_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alloc_req) |-> $past(rel_req));

    assert_fail_requested_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_done && !sw_timeout) |-> ((sw_result & ~nxt_cap) == '0));

    assert_timeout_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sw_timeout |-> (sw_done && (sw_result == '1)));

    if (SINGLE_HART) begin : g_single_chk
        assert_no_alloc_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !rel_req && !alloc_req);
    end

endmodule

// File: tb/tb_dsw_switch_ctrl.sv
`timescale 1ns/100ps
module tb_dsw_switch_ctrl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        csr_we;
    logic        csr_addr;
    logic [11:0] csr_wdata;
    logic        sw_req;
    logic [2:0]  flush_done;
    logic [1:0]  gnt;
    logic [7:0]  deny;

    logic [11:0] rdata_m, rdata_s;
    logic        stall_m, stall_s, done_m, done_s, tmo_m, tmo_s;
    logic [3:0]  res_m, res_s, acap_m, acap_s;
    logic [2:0]  freq_m, freq_s;
    logic [7:0]  fid_m, fid_s, rid_m, rid_s, aid_m, aid_s;
    logic        rel_m, rel_s, areq_m, areq_s;

    always #2.5 clk = ~clk;

    dsw_switch_ctrl #(.ID_W(8), .CAP_W(4), .N_FLUSH(3), .N_ALLOC(2),
                      .TMO_CYC(40), .SINGLE_HART(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(rdata_m), .sw_req(sw_req),
        .sw_stall(stall_m), .sw_done(done_m), .sw_result(res_m),
        .sw_timeout(tmo_m), .flush_req(freq_m), .flush_id(fid_m),
        .flush_done(flush_done), .rel_req(rel_m), .rel_id(rid_m),
        .alloc_req(areq_m), .alloc_id(aid_m), .alloc_cap(acap_m),
        .alloc_gnt(gnt), .alloc_deny(deny));

    dsw_switch_ctrl #(.ID_W(8), .CAP_W(4), .N_FLUSH(3), .N_ALLOC(2),
                      .TMO_CYC(40), .SINGLE_HART(1'b1)) dut_s (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(rdata_s), .sw_req(sw_req),
        .sw_stall(stall_s), .sw_done(done_s), .sw_result(res_s),
        .sw_timeout(tmo_s), .flush_req(freq_s), .flush_id(fid_s),
        .flush_done(flush_done), .rel_req(rel_s), .rel_id(rid_s),
        .alloc_req(areq_s), .alloc_id(aid_s), .alloc_cap(acap_s),
        .alloc_gnt(2'b00), .alloc_deny(8'h00));

    int n_vec = 0;
    int n_bad = 0;

    // reference state: index 0 = multi-hart instance, 1 = single-hart instance
    logic [11:0] m_cur [2];
    logic [11:0] m_nxt [2];
    bit          m_busy [2];
    bit          mon_en = 1'b0;
    bit          wr_pend = 1'b0;
    logic        wr_a;
    logic [11:0] wr_d;
    logic        rot = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] got,
                       input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    // model update at the active edge, using values present before it
    always @(posedge clk) begin
        if (rst_n) begin
            for (int k = 0; k < 2; k++) begin
                bit          stl;
                bit          dn;
                logic [3:0]  rs;
                stl = m_busy[k] || sw_req;
                dn  = (k == 0) ? done_m : done_s;
                rs  = (k == 0) ? res_m : res_s;
                if (csr_we && csr_addr && !stl) m_nxt[k] = csr_wdata;
                if (sw_req && !m_busy[k]) m_busy[k] = 1'b1;
                if (dn) begin
                    m_busy[k] = 1'b0;
                    if (rs == 4'h0) m_cur[k] = m_nxt[k];
                end
            end
        end
    end

    // per-cycle comparison away from the edge, then CSR port driving
    always @(negedge clk) begin
        #1;
        if (rst_n && mon_en) begin
            chk(rdata_m == (csr_addr ? m_nxt[0] : m_cur[0]),
                "R1/R3/R5/R7 csr read multi", 32'(rdata_m),
                32'(csr_addr ? m_nxt[0] : m_cur[0]));
            chk(rdata_s == (csr_addr ? m_nxt[1] : m_cur[1]),
                "R1/R3/R5/R7 csr read single", 32'(rdata_s),
                32'(csr_addr ? m_nxt[1] : m_cur[1]));
            chk(stall_m == (m_busy[0] || sw_req), "R2 stall multi",
                32'(stall_m), 32'(m_busy[0] || sw_req));
            chk(stall_s == (m_busy[1] || sw_req), "R2 stall single",
                32'(stall_s), 32'(m_busy[1] || sw_req));
            chk(!rel_s && !areq_s, "R8 single no release/alloc",
                32'({rel_s, areq_s}), 32'h0);
        end
        if (wr_pend) begin
            csr_we    = 1'b1;
            csr_addr  = wr_a;
            csr_wdata = wr_d;
            wr_pend   = 1'b0;
        end else begin
            csr_we    = 1'b0;
            csr_addr  = rot;
            rot       = ~rot;
        end
    end

    task automatic csr_write(input logic a, input logic [11:0] v);
        @(negedge clk);
        wr_pend = 1'b1;
        wr_a    = a;
        wr_d    = v;
        @(negedge clk);
    endtask

    task automatic run_switch(input int d0, input int d1, input int d2, input bit hang,
                              input int g0, input int g1,
                              input logic [3:0] dn0, input logic [3:0] dn1,
                              input bit midwr, input logic [11:0] mwd);
        int dmax;
        int gmax;
        logic [3:0] expres;
        bit seen;
        dmax = (d0 > d1) ? d0 : d1;
        dmax = (d2 > dmax) ? d2 : dmax;
        gmax = (g0 > g1) ? g0 : g1;
        @(negedge clk);
        sw_req = 1'b1;
        @(negedge clk);
        sw_req = 1'b0;
        chk(freq_m == 3'b111, "R4 flush pulse multi", 32'(freq_m), 32'h7);
        chk(freq_s == 3'b111, "R4 flush pulse single", 32'(freq_s), 32'h7);
        chk(fid_m == m_cur[0][7:0], "R4 flush id", 32'(fid_m), 32'(m_cur[0][7:0]));
        for (int t = 1; t <= dmax; t++) begin
            @(negedge clk);
            flush_done = {(t == d2) && !hang, t == d1, t == d0};
            if (t == 1 && midwr) begin
                wr_pend = 1'b1;
                wr_a    = 1'b1;
                wr_d    = mwd;
            end
            chk(!rel_m && !areq_m, "R4 no release before flush done",
                32'({rel_m, areq_m}), 32'h0);
        end
        if (hang) begin
            @(negedge clk);
            flush_done = 3'b000;
            seen = 1'b0;
            for (int w = 0; w < 100 && !seen; w++) begin
                if (done_m) seen = 1'b1;
                else begin
                    chk(!rel_m, "R9 no release while hung", 32'(rel_m), 32'h0);
                    @(negedge clk);
                end
            end
            chk(done_m && tmo_m && res_m == 4'hF, "R9 timeout multi",
                32'({done_m, tmo_m, res_m}), 32'h3F);
            chk(done_s && tmo_s && res_s == 4'hF, "R9 timeout single",
                32'({done_s, tmo_s, res_s}), 32'h3F);
            return;
        end
        @(negedge clk);
        flush_done = 3'b000;
        chk(rel_m, "R4 release after last flush", 32'(rel_m), 32'h1);
        chk(rid_m == m_cur[0][7:0], "R4 release id", 32'(rid_m), 32'(m_cur[0][7:0]));
        chk(!areq_m, "R4 no alloc during release", 32'(areq_m), 32'h0);
        chk(done_s && res_s == 4'h0 && !tmo_s, "R8 single commit after flush",
            32'({done_s, tmo_s, res_s}), 32'h20);
        for (int t = 0; t <= gmax; t++) begin
            @(negedge clk);
            gnt  = {t == g1, t == g0};
            deny = {(t == g1) ? dn1 : 4'h0, (t == g0) ? dn0 : 4'h0};
            chk(areq_m && aid_m == m_nxt[0][7:0] && acap_m == m_nxt[0][11:8],
                "R4 alloc request", 32'({areq_m, acap_m, aid_m}),
                32'({1'b1, m_nxt[0]}));
            chk(!done_m, "R5 no early done", 32'(done_m), 32'h0);
        end
        @(negedge clk);
        gnt    = 2'b00;
        deny   = 8'h00;
        expres = (dn0 | dn1) & m_nxt[0][11:8];
        chk(done_m && !tmo_m && res_m == expres, "R5/R6 switch result",
            32'({done_m, tmo_m, res_m}), 32'({1'b1, 1'b0, expres}));
        chk(!areq_m, "R4 alloc dropped at done", 32'(areq_m), 32'h0);
    endtask

    initial begin
        rst_n      = 1'b0;
        csr_we     = 1'b0;
        csr_addr   = 1'b0;
        csr_wdata  = '0;
        sw_req     = 1'b0;
        flush_done = '0;
        gnt        = '0;
        deny       = '0;
        for (int k = 0; k < 2; k++) begin
            m_cur[k]  = '0;
            m_nxt[k]  = '0;
            m_busy[k] = 1'b0;
        end
        repeat (4) @(negedge clk);
        chk(!stall_m && !done_m && res_m == 4'h0, "R2 reset idle",
            32'({stall_m, done_m, res_m}), 32'h0);
        chk(rdata_m == 12'h000, "R1 reset value", 32'(rdata_m), 32'h0);
        rst_n  = 1'b1;
        mon_en = 1'b1;
        repeat (4) @(negedge clk);

        csr_write(1'b0, 12'hABC);             // R1: read-only current register
        repeat (2) @(negedge clk);
        csr_write(1'b1, {4'h3, 8'h5A});
        repeat (2) @(negedge clk);
        run_switch(1, 3, 2, 1'b0, 0, 2, 4'h0, 4'h0, 1'b0, 12'h000);   // R5 success
        repeat (3) @(negedge clk);

        csr_write(1'b1, {4'hF, 8'h21});
        run_switch(2, 2, 1, 1'b0, 1, 0, 4'b0100, 4'b0001, 1'b1, 12'h777); // R6 R7 R3
        repeat (3) @(negedge clk);

        csr_write(1'b1, {4'h2, 8'h33});
        run_switch(2, 2, 2, 1'b0, 1, 1, 4'h1, 4'h0, 1'b0, 12'h000);   // R6 unrequested deny
        repeat (3) @(negedge clk);

        csr_write(1'b1, {4'h8, 8'h44});
        run_switch(1, 1, 1, 1'b1, 0, 0, 4'h0, 4'h0, 1'b0, 12'h000);   // R9 hung flush
        repeat (3) @(negedge clk);

        run_switch(4, 1, 1, 1'b0, 3, 0, 4'h0, 4'h0, 1'b0, 12'h000);   // recovery
        repeat (5) @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog expired got 0 exp 1");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule